// File: doc/BRIEF.md
# Texture Block-Load Engine with Row Swizzle

This engine moves one flat run of texels from a 64-bit-wide system memory into a 4096-byte on-chip texture store. A single start command gives the source byte address, the index of the last texel, a texel-size code, the destination line in 8-byte units, and a fixed-point line-advance value. The engine reads one 64-bit word per beat over a valid/ready request channel and writes each returned word into the texture store with a write strobe.

The flat copy is cut into virtual rows. When the line-advance value is nonzero, each row spans ceil(2048 / advance) words. Words in odd rows are rearranged as they are written, and the rearrangement depends on the texel size. A line-advance of zero turns this off and gives a plain copy. Before any access is made, a load whose source or destination would run past the end of its memory is rejected as a whole.

Top module: `tex_block_loader`

## Requirements
- R1: A command moves exactly W = (B + 7) >> 3 words, where B = ((last + 1) << size) >> 1 bytes. It issues exactly W read requests and W write strobes. Size codes: 0 = 4-bit, 1 = 8-bit, 2 = 16-bit, 3 = 32-bit.
- R2: Word k is read from byte address src + 8·k and written to texture word address (line + k) mod 512, before any odd-row remapping. A load that ends exactly at byte 4096 is accepted.
- R3: With a line-advance of zero, every word is written unchanged at its R2 address.
- R4: With a nonzero line-advance A, word k belongs to row k / ceil(2048 / A), using integer division. The last row may be shorter than the others.
- R5: In size codes 0 to 2, a word in an odd row is written as {d[31:0], d[63:32]} at its R2 address.
- R6: In size code 3, a word in an odd row keeps its data unchanged, and bit 0 of its R2 word address is inverted.
- R7: Row parity restarts at even for every command, whatever the row parity was when the previous command ended.
- R8: A command is faulted if src + B > RAM size or line·8 + B > 4096. A faulted command pulses err for one cycle, raises no done, and makes no read and no write.
- R9: If B is zero, the command pulses done without any read or write.
- R10: A read request holds its valid and address stable until it is accepted. Only one read is outstanding at a time, and a write happens only in the cycle after a response. Reset leaves no request pending.
- R11: busy is high from the cycle after a command is accepted until the done or err pulse, and it is low during that pulse. Commands offered while busy are ignored. done pulses in the same cycle as the final write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start a load; taken only when idle |
| cmd_src | input | ADDR_W | Source byte address |
| cmd_last | input | IDX_W | Index of the last texel |
| cmd_size | input | 2 | Texel-size code |
| cmd_line | input | LINE_W | Destination line, in 8-byte units |
| cmd_adv | input | ADV_W | Line-advance value; zero means straight copy |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle range-fault pulse |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Read data |
| tm_we | output | 1 | Texture store write strobe |
| tm_addr | output | LINE_W | Texture store word address |
| tm_wdata | output | 64 | Texture store write data |

## Verification
The bench builds the engine with a 20-bit address and a 64 KiB RAM size. With these values the source-end fault and the exact-fit case can be reached at small addresses that the bench memory model serves directly. The advance and texel-index widths stay at 12 bits. This brings in reach an advance of 4095, where every word is its own row, the widest numerator the divider has to handle, and loads of hundreds of words that fill the destination up to its last word.

// File: rtl/tbl_pkg.sv
package tbl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_DIV,
      ST_REQ,
      ST_RSP
   } ld_state_e;

   localparam logic [1:0] SZ_32B = 2'd3;
   localparam int WORD_SHIFT = 3;

endpackage

// File: rtl/tbl_ceil_div.sv
module tbl_ceil_div #(
   parameter int DEN_W = 12,
   parameter int SPAN  = 2048,
   parameter int NUM_W = $clog2(SPAN + (1 << DEN_W))
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DEN_W-1:0] den,
   output logic             done,
   output logic [NUM_W-1:0] quo
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   if (SPAN < 1) begin : g_bad_span
      $error("tbl_ceil_div: SPAN must be positive");
   end

   logic [NUM_W-1:0] num_q;
   logic [NUM_W:0]   rem_q, rem_sh, rem_nx, den_ext;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             active_q, fits;

   assign den_ext = (NUM_W + 1)'(den_q);
   assign rem_sh  = {rem_q[NUM_W-1:0], num_q[NUM_W-1]};
   assign fits    = (rem_sh >= den_ext);
   assign rem_nx  = fits ? (rem_sh - den_ext) : rem_sh;
   assign quo     = num_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_q    <= '0;
         rem_q    <= '0;
         den_q    <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            num_q    <= NUM_W'(SPAN) + NUM_W'(den) - NUM_W'(1);
            rem_q    <= '0;
            den_q    <= den;
            cnt_q    <= CNT_W'(NUM_W);
            active_q <= 1'b1;
         end else if (active_q) begin
            rem_q <= rem_nx;
            num_q <= {num_q[NUM_W-2:0], fits};
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
               active_q <= 1'b0;
               done     <= 1'b1;
            end
         end
      end
   end

   // R4: divisor is never zero when a divide starts
   a_r4_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (den != '0));

   // R4: the quotient is the ceiling of SPAN over the divisor
   a_r4_ceil_result: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((int'(quo) * int'(den_q) >= SPAN) &&
                ((int'(quo) - 1) * int'(den_q) < SPAN)));

endmodule

// File: rtl/tbl_row_track.sv
module tbl_row_track #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             adv_en,
   input  logic [CNT_W-1:0] wpr,
   input  logic             step,
   output logic             odd
);
   logic [CNT_W-1:0] cnt_q;
   logic             row_end;

   assign row_end = (cnt_q == wpr - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         odd   <= 1'b0;
      end else if (clear) begin
         cnt_q <= '0;
         odd   <= 1'b0;
      end else if (step && adv_en) begin
         if (row_end) begin
            cnt_q <= '0;
            odd   <= ~odd;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   // R7: parity is even right after a new command clears the tracker
   a_r7_even_start: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !odd);

   // R4: position inside the row never reaches the row length
   a_r4_cnt_in_row: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && step && (wpr != '0)) |-> (cnt_q < wpr));

endmodule

// File: rtl/tbl_swizzle.sv
module tbl_swizzle #(
   parameter int LANES  = 2,
   parameter int LANE_W = 32,
   parameter int AW     = 9
) (
   input  logic                    odd,
   input  logic                    wide,
   input  logic [LANES*LANE_W-1:0] din,
   input  logic [AW-1:0]           ain,
   output logic [LANES*LANE_W-1:0] dout,
   output logic [AW-1:0]           aout
);
   logic flip_lane, flip_addr;

   if (LANES < 2) begin : g_bad_lanes
      $error("tbl_swizzle: at least two lanes are needed");
   end

   assign flip_lane = odd && !wide;
   assign flip_addr = odd && wide;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign dout[g*LANE_W +: LANE_W] = flip_lane ?
         din[(LANES-1-g)*LANE_W +: LANE_W] : din[g*LANE_W +: LANE_W];
   end

   assign aout = ain ^ AW'(flip_addr);

endmodule

// File: rtl/tex_block_loader.sv
module tex_block_loader
   import tbl_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int RAM_BYTES  = 1 << 24,
   parameter int TMEM_BYTES = 4096,
   parameter int LINE_W     = 9,
   parameter int IDX_W      = 12,
   parameter int ADV_W      = 12,
   parameter int ROW_SPAN   = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [ADDR_W-1:0] cmd_src,
   input  logic [IDX_W-1:0]  cmd_last,
   input  logic [1:0]        cmd_size,
   input  logic [LINE_W-1:0] cmd_line,
   input  logic [ADV_W-1:0]  cmd_adv,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   input  logic              rd_rsp_valid,
   input  logic [63:0]       rd_rsp_data,
   output logic              tm_we,
   output logic [LINE_W-1:0] tm_addr,
   output logic [63:0]       tm_wdata
);
   localparam int LEN_W = IDX_W + 4;
   localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;
   localparam int DST_W = (((LINE_W + WORD_SHIFT) > LEN_W) ? (LINE_W + WORD_SHIFT) : LEN_W) + 1;
   localparam int QW    = $clog2(ROW_SPAN + (1 << ADV_W));

   if (TMEM_BYTES != (8 << LINE_W)) begin : g_bad_line
      $error("tex_block_loader: LINE_W does not match TMEM_BYTES");
   end
   if (RAM_BYTES > (1 << ADDR_W)) begin : g_bad_ram
      $error("tex_block_loader: RAM_BYTES exceeds the address range");
   end

   ld_state_e         st;
   logic [ADDR_W-1:0] src_q;
   logic [1:0]        size_q;
   logic [LINE_W-1:0] line_q;
   logic [ADV_W-1:0]  adv_q;
   logic [LEN_W-1:0]  bytes_q, words_q, idx_q, len_in;
   logic [SUM_W-1:0]  src_end;
   logic [DST_W-1:0]  dst_end;
   logic [QW-1:0]     wpr;
   logic [63:0]       sw_data;
   logic [LINE_W-1:0] sw_addr;
   logic              fault, accept, div_start, div_done, rsp_take, last_word, row_odd;

   assign len_in    = ((LEN_W'(cmd_last) + LEN_W'(1)) << cmd_size) >> 1;
   assign src_end   = SUM_W'(src_q) + SUM_W'(bytes_q);
   assign dst_end   = (DST_W'(line_q) << WORD_SHIFT) + DST_W'(bytes_q);
   assign fault     = (src_end > SUM_W'(RAM_BYTES)) || (dst_end > DST_W'(TMEM_BYTES));
   assign accept    = (st == ST_IDLE) && cmd_valid;
   assign div_start = (st == ST_CHECK) && !fault && (words_q != '0) && (adv_q != '0);
   assign rsp_take  = (st == ST_RSP) && rd_rsp_valid;
   assign last_word = (idx_q == words_q - LEN_W'(1));

   assign busy         = (st != ST_IDLE);
   assign rd_req_valid = (st == ST_REQ);
   assign rd_req_addr  = src_q + ADDR_W'({idx_q, 3'b000});

   tbl_ceil_div #(.DEN_W(ADV_W), .SPAN(ROW_SPAN), .NUM_W(QW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .den   (adv_q),
      .done  (div_done),
      .quo   (wpr)
   );

   tbl_row_track #(.CNT_W(QW)) u_rows (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .adv_en (adv_q != '0),
      .wpr    (wpr),
      .step   (rsp_take),
      .odd    (row_odd)
   );

   tbl_swizzle #(.LANES(2), .LANE_W(32), .AW(LINE_W)) u_swz (
      .odd  (row_odd),
      .wide (size_q == SZ_32B),
      .din  (rd_rsp_data),
      .ain  (line_q + LINE_W'(idx_q)),
      .dout (sw_data),
      .aout (sw_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         src_q    <= '0;
         size_q   <= '0;
         line_q   <= '0;
         adv_q    <= '0;
         bytes_q  <= '0;
         words_q  <= '0;
         idx_q    <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         tm_we    <= 1'b0;
         tm_addr  <= '0;
         tm_wdata <= '0;
      end else begin
         done  <= 1'b0;
         err   <= 1'b0;
         tm_we <= 1'b0;
         case (st)
            ST_IDLE: if (cmd_valid) begin
               src_q   <= cmd_src;
               size_q  <= cmd_size;
               line_q  <= cmd_line;
               adv_q   <= cmd_adv;
               bytes_q <= len_in;
               words_q <= (len_in + LEN_W'(7)) >> WORD_SHIFT;
               idx_q   <= '0;
               st      <= ST_CHECK;
            end
            ST_CHECK: begin
               if (fault) begin
                  err <= 1'b1;
                  st  <= ST_IDLE;
               end else if (words_q == '0) begin
                  done <= 1'b1;
                  st   <= ST_IDLE;
               end else if (adv_q != '0) begin
                  st <= ST_DIV;
               end else begin
                  st <= ST_REQ;
               end
            end
            ST_DIV: if (div_done) st <= ST_REQ;
            ST_REQ: if (rd_req_ready) st <= ST_RSP;
            ST_RSP: if (rd_rsp_valid) begin
               tm_we    <= 1'b1;
               tm_addr  <= sw_addr;
               tm_wdata <= sw_data;
               idx_q    <= idx_q + LEN_W'(1);
               if (last_word) begin
                  done <= 1'b1;
                  st   <= ST_IDLE;
               end else begin
                  st <= ST_REQ;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R10: a stalled request keeps valid and address
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

   // R10: a write strobe always follows a read response
   a_r10_write_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      tm_we |-> $past(rd_rsp_valid));

   // R8: a faulted command writes nothing and raises no done
   a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!tm_we && !done));

   // R11: the engine is idle while it reports completion or fault
   a_r11_idle_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> !busy);

endmodule

// File: tb/test_tex_block_loader.sv
`timescale 1ns/1ps
module test_tex_block_loader;
   localparam int ADDR_W    = 20;
   localparam int RAM_BYTES = 65536;
   localparam int IDX_W     = 12;
   localparam int ADV_W     = 12;
   localparam int LINE_W    = 9;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [ADDR_W-1:0] cmd_src = '0;
   logic [IDX_W-1:0]  cmd_last = '0;
   logic [1:0]        cmd_size = '0;
   logic [LINE_W-1:0] cmd_line = '0;
   logic [ADV_W-1:0]  cmd_adv = '0;
   logic              busy, done, err, rd_req_valid, rd_req_ready, rd_rsp_valid, tm_we;
   logic [ADDR_W-1:0] rd_req_addr;
   logic [63:0]       rd_rsp_data, tm_wdata;
   logic [LINE_W-1:0] tm_addr;

   tex_block_loader #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .TMEM_BYTES(4096),
                      .LINE_W(LINE_W), .IDX_W(IDX_W), .ADV_W(ADV_W), .ROW_SPAN(2048))
   i_tex_block_loader (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
      .cmd_last(cmd_last), .cmd_size(cmd_size), .cmd_line(cmd_line), .cmd_adv(cmd_adv),
      .busy(busy), .done(done), .err(err), .rd_req_valid(rd_req_valid),
      .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
      .rd_rsp_data(rd_rsp_data), .tm_we(tm_we), .tm_addr(tm_addr), .tm_wdata(tm_wdata)
   );

   function automatic logic [63:0] memf(input logic [ADDR_W-1:0] a);
      logic [31:0] x;
      x = 32'(a);
      return {32'h5A00_0000 ^ (x * 32'd7), 32'h00A5_0000 + x};
   endfunction

   // memory model with ready stalls and variable response latency
   logic [3:0]        pat;
   logic              pend;
   logic [ADDR_W-1:0] paddr;
   logic [2:0]        dly;
   assign rd_req_ready = (pat[1:0] != 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat <= '0; pend <= 1'b0; paddr <= '0; dly <= '0;
         rd_rsp_valid <= 1'b0; rd_rsp_data <= '0;
      end else begin
         pat <= pat + 4'd1;
         rd_rsp_valid <= 1'b0;
         if (rd_req_valid && rd_req_ready && !pend) begin
            pend <= 1'b1; paddr <= rd_req_addr; dly <= pat[3:1];
         end else if (pend) begin
            if (dly == 3'd0) begin
               rd_rsp_valid <= 1'b1; rd_rsp_data <= memf(paddr); pend <= 1'b0;
            end else begin
               dly <= dly - 3'd1;
            end
         end
      end
   end

   typedef struct {
      logic [LINE_W-1:0] a;
      logic [63:0]       d;
      string             tag;
   } exp_t;
   exp_t q[$];

   int checks = 0, fails = 0, done_n = 0, err_n = 0, req_n = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=0x%0h exp=0x%0h", tag, what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      exp_t e;
      if (rst_n) begin
         if (rd_req_valid && rd_req_ready) req_n++;
         if (done) done_n++;
         if (err) err_n++;
         if (tm_we) begin
            if (q.size() == 0) begin
               chk(1'b0, "R1", "unexpected write", longint'(tm_addr), 0);
            end else begin
               e = q.pop_front();
               chk(tm_addr == e.a, e.tag, "write address", longint'(tm_addr), longint'(e.a));
               chk(tm_wdata == e.d, e.tag, "write data", longint'(tm_wdata), longint'(e.d));
            end
         end
      end
   end

   task automatic run_cmd(input int src, input int last, input int size, input int line,
                          input int adv, input bit hold, input string ovr);
      int bytes, words, wpr, row, d0, e0, r0, t;
      bit fault, odd;
      exp_t e;
      logic [63:0] d;
      bytes = ((last + 1) << size) >> 1;
      words = (bytes + 7) / 8;
      fault = (src + bytes > RAM_BYTES) || (line * 8 + bytes > 4096);
      wpr   = (adv != 0) ? (2048 + adv - 1) / adv : 0;
      if (!fault) begin
         for (int k = 0; k < words; k++) begin
            row = (adv != 0) ? k / wpr : 0;
            odd = row[0];
            d   = memf(ADDR_W'(src + 8 * k));
            e.a = LINE_W'((line + k) % 512);
            if (odd && size == 3) e.a = e.a ^ LINE_W'(1);
            else if (odd) d = {d[31:0], d[63:32]};
            e.d = d;
            if (ovr != "") e.tag = ovr;
            else if (adv == 0) e.tag = "R3";
            else if (odd) e.tag = (size == 3) ? "R6" : "R5";
            else e.tag = "R4";
            q.push_back(e);
         end
      end
      d0 = done_n; e0 = err_n; r0 = req_n;
      @(negedge clk);
      cmd_src = ADDR_W'(src); cmd_last = IDX_W'(last); cmd_size = 2'(size);
      cmd_line = LINE_W'(line); cmd_adv = ADV_W'(adv); cmd_valid = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1, "R11", "busy after accept", longint'(busy), 1);
      if (hold) begin
         cmd_src = cmd_src ^ ADDR_W'('h40);
         cmd_line = cmd_line ^ LINE_W'(3);
         @(negedge clk);
         chk(busy == 1'b1, "R11", "busy while command held", longint'(busy), 1);
      end
      cmd_valid = 1'b0;
      t = 0;
      while (done_n == d0 && err_n == e0 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(t < 5000, "R11", "completion timeout", t, 0);
      if (fault) begin
         chk(err_n == e0 + 1, "R8", "err pulses", err_n - e0, 1);
         chk(done_n == d0, "R8", "done pulses on fault", done_n - d0, 0);
         chk(req_n == r0, "R8", "reads on fault", req_n - r0, 0);
      end else begin
         chk(done_n == d0 + 1, (words == 0) ? "R9" : "R11", "done pulses", done_n - d0, 1);
         chk(err_n == e0, "R8", "err on legal load", err_n - e0, 0);
         chk(req_n - r0 == words, "R1 R10", "read request count", req_n - r0, words);
      end
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R11", "idle after end", longint'(busy), 0);
      chk(q.size() == 0, "R1", "missing writes", q.size(), 0);
      q.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R11 watchdog act=0x1 exp=0x0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      chk(busy == 1'b0, "R11", "reset busy", longint'(busy), 0);
      chk(rd_req_valid == 1'b0, "R10", "reset request", longint'(rd_req_valid), 0);
      chk(tm_we == 1'b0 && done == 1'b0 && err == 1'b0, "R11", "reset strobes",
          longint'({tm_we, done, err}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      run_cmd('h0100,   31, 2,   0,    0, 1'b0, "");    // R3 straight copy
      run_cmd('h2003,   63, 2,  16,  512, 1'b1, "");    // R4 R5, held command R11
      run_cmd('h3000,   39, 2, 100,  700, 1'b0, "");    // R4 rows 3,3,3,1
      run_cmd('h3800,    7, 2,  40,  512, 1'b0, "R7");  // parity restarts even
      run_cmd('h4000,   15, 3, 200, 1024, 1'b0, "");    // R6 32-bit remap
      run_cmd('h4400,   63, 1, 300, 4095, 1'b0, "");    // R4 one word per row
      run_cmd('h5000,    0, 0,   0,    0, 1'b0, "R9");  // zero length
      run_cmd('h5000,   14, 0,   5,    0, 1'b0, "R1");  // 7 bytes -> 1 word
      run_cmd('h6000,   15, 2, 510,    0, 1'b0, "R8");  // destination overrun
      run_cmd('h6000,   15, 2, 508,    0, 1'b0, "R2");  // ends at byte 4096
      run_cmd(65536-32, 15, 2,   0,    0, 1'b0, "R2");  // source ends at RAM size
      run_cmd(65536-24, 15, 2,   0,    0, 1'b0, "R8");  // source overrun
      run_cmd('h0800, 2047, 2,   0,    1, 1'b0, "R4");  // one long even row
      run_cmd('h1000,  255, 3, 256,    3, 1'b0, "");    // 32-bit, rows of 683

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule